// File: doc/BRIEF.md
# Program Address Match Interrupt Unit

This unit watches the instruction-fetch address a CPU places on its internal program address bus. It offers a set of match channels, two by default. Each channel holds a target address that software loads one byte at a time over a byte-wide register bus. When an opcode fetch presents a channel's target and that channel is enabled, the unit latches the channel's detect flag. It also asks the CPU to execute a software-interrupt instruction in place of the fetched opcode. This lets code held in ROM be patched: the interrupt handler runs replacement code held elsewhere.

The control and status byte holds one enable bit and one detect flag per channel. A flag stays set until software writes 0 to it. The request output is a single-cycle pulse, registered one cycle after the matching fetch. It fires only for a channel whose flag was still clear. Matches on several channels in the same cycle give one pulse and set every matching flag.

Top module: `fetch_match_irq`

## Requirements
- R1: Target bytes are writable and readable at fixed byte addresses: channel 0 low, middle and high at 0x1FF0, 0x1FF1 and 0x1FF2, and channel 1 low, middle and high at 0x1FF3, 0x1FF4 and 0x1FF5. A read returns the last value written, combinationally on `reg_rdata`.
- R2: The control/status byte sits at 0x1FF6. Bit 2i is channel i's enable and bit 2i+1 is its detect flag. Bits above those read 0. After reset it reads 0x00 and `swi_req` is 0.
- R3: A fetch address is compared only while `fetch_valid` is 1. A matching address with `fetch_valid` at 0 sets no flag and raises no request.
- R4: A fetch cycle whose address equals an enabled channel's full target, with that channel's flag clear, sets the flag at the next edge. It also drives `swi_req` to 1 for exactly the next cycle.
- R5: A match on a channel whose enable bit is 0 sets no flag and raises no request.
- R6: When two channels match in the same fetch cycle, both flags are set and `swi_req` is a single one-cycle pulse.
- R7: A set flag stays set until a control/status write carries 0 in that flag's bit. Writing 1 to a flag bit never sets it. A match in the same cycle as a clearing write leaves the flag set.
- R8: A match on a channel whose flag is already set raises no request.
- R9: A write to an address outside 0x1FF0 to 0x1FF6 changes no register, and such an address reads 0x00.
- R10: All 24 target bits take part in the compare. An address that differs from a target in any one byte does not match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for enables, flags and the request |
| reg_addr | input | 16 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| fetch_valid | input | 1 | High in cycles that fetch an opcode |
| fetch_addr | input | 24 | Program address of the current fetch |
| swi_req | output | 1 | One-cycle software-interrupt request |

## Verification
The checker assumes every target byte has been written before its channel is enabled, because target bytes come out of reset undefined. The bench therefore loads both targets before it sets any enable bit. The checker also assumes `reg_addr`, `reg_wr` and the fetch inputs are settled at each rising edge. The bench changes them only on the falling edge and holds a fetch for exactly one cycle. Between fetches it returns `fetch_valid` to 0, so each pulse can be tied to a single fetch.

// File: rtl/fmi_pkg.sv
package fmi_pkg;
   localparam int unsigned BYTE_W = 8;

   // Bit position of a channel's enable inside the control/status byte
   function automatic int unsigned en_pos(int unsigned ch);
      return 2 * ch;
   endfunction

   // Bit position of a channel's detect flag inside the control/status byte
   function automatic int unsigned flag_pos(int unsigned ch);
      return 2 * ch + 1;
   endfunction
endpackage

// File: rtl/fmi_target.sv
module fmi_target #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned RAW    = 16,
   parameter logic [RAW-1:0] BASE = '0
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [RAW-1:0]    acc_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [ADDR_W-1:0] target,
   output logic              addr_eq,
   output logic              rd_sel,
   output logic [7:0]        rd_byte
);
   localparam int unsigned NB = ADDR_W / fmi_pkg::BYTE_W;

   logic [NB-1:0] byte_sel;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam logic [RAW-1:0] BADDR = BASE + RAW'(b);
      assign byte_sel[b] = (acc_addr == BADDR);
      // target bytes carry no reset: software loads them before enabling
      always_ff @(posedge clk) begin
         if (wr_en && byte_sel[b]) target[b*8 +: 8] <= wr_data;
      end
   end

   assign addr_eq = (fetch_addr == target);
   assign rd_sel  = |byte_sel;

   always_comb begin
      rd_byte = '0;
      for (int b = 0; b < NB; b++) begin
         if (byte_sel[b]) rd_byte = target[b*8 +: 8];
      end
   end
endmodule

// File: rtl/fmi_chan_ctl.sv
module fmi_chan_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic csr_we,
   input  logic wr_en_bit,
   input  logic wr_flag_bit,
   input  logic fetch_valid,
   input  logic addr_eq,
   output logic en,
   output logic flag,
   output logic hit
);
   logic set_now;

   assign set_now = fetch_valid & en & addr_eq;
   // only a first match (flag still clear) asks for an interrupt
   assign hit     = set_now & ~flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (csr_we) en <= wr_en_bit;
         if (set_now)                      flag <= 1'b1;
         else if (csr_we && !wr_flag_bit)  flag <= 1'b0;
      end
   end
endmodule

// File: rtl/fetch_match_irq.sv
module fetch_match_irq #(
   parameter int unsigned     ADDR_W   = 24,
   parameter int unsigned     NCH      = 2,
   parameter int unsigned     RAW      = 16,
   parameter logic [15:0]     TGT_BASE = 16'h1FF0,
   parameter logic [15:0]     CSR_ADDR = 16'h1FF6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAW-1:0]    reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              swi_req
);
   localparam int unsigned NB       = ADDR_W / fmi_pkg::BYTE_W;
   localparam int unsigned TGT_SPAN = NCH * NB;
   localparam int unsigned CSR_BITS = 2 * NCH;

   if (ADDR_W % fmi_pkg::BYTE_W != 0) begin : g_chk_w
      $error("ADDR_W must be a whole number of bytes");
   end
   if (CSR_BITS > 8) begin : g_chk_n
      $error("NCH must fit two bits per channel in one byte");
   end
   if (RAW > 16) begin : g_chk_a
      $error("RAW wider than the address parameters");
   end
   if ((CSR_ADDR >= TGT_BASE) && (CSR_ADDR < TGT_BASE + 16'(TGT_SPAN))) begin : g_chk_c
      $error("CSR_ADDR overlaps the target byte window");
   end

   logic [NCH-1:0]        en_vec, flag_vec, hit_vec, eq_vec, rd_sel_vec;
   logic [NCH*ADDR_W-1:0] tgt_flat;
   logic [7:0]            rd_byte [NCH];
   logic                  csr_sel, csr_we;
   logic [7:0]            csr_img;
   logic                  req_q;

   assign csr_sel = (reg_addr == RAW'(CSR_ADDR));
   assign csr_we  = reg_wr & csr_sel;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam logic [RAW-1:0] CH_BASE = RAW'(TGT_BASE) + RAW'(i * NB);

      fmi_target #(.ADDR_W(ADDR_W), .RAW(RAW), .BASE(CH_BASE)) u_tgt (
         .clk        (clk),
         .wr_en      (reg_wr),
         .acc_addr   (reg_addr),
         .wr_data    (reg_wdata),
         .fetch_addr (fetch_addr),
         .target     (tgt_flat[i*ADDR_W +: ADDR_W]),
         .addr_eq    (eq_vec[i]),
         .rd_sel     (rd_sel_vec[i]),
         .rd_byte    (rd_byte[i])
      );

      fmi_chan_ctl u_ctl (
         .clk         (clk),
         .rst_n       (rst_n),
         .csr_we      (csr_we),
         .wr_en_bit   (reg_wdata[fmi_pkg::en_pos(i)]),
         .wr_flag_bit (reg_wdata[fmi_pkg::flag_pos(i)]),
         .fetch_valid (fetch_valid),
         .addr_eq     (eq_vec[i]),
         .en          (en_vec[i]),
         .flag        (flag_vec[i]),
         .hit         (hit_vec[i])
      );
   end

   always_comb begin
      csr_img = '0;
      for (int i = 0; i < NCH; i++) begin
         csr_img[fmi_pkg::en_pos(i)]   = en_vec[i];
         csr_img[fmi_pkg::flag_pos(i)] = flag_vec[i];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_sel_vec[i]) reg_rdata = rd_byte[i];
      end
      if (csr_sel) reg_rdata = csr_img;
   end

   // one request regardless of how many channels hit together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= |hit_vec;
   end

   assign swi_req = req_q;
endmodule

// File: rtl/fmi_checker.sv
module fmi_checker #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned NCH      = 2,
   parameter int unsigned RAW      = 16,
   parameter logic [15:0] CSR_ADDR = 16'h1FF6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [RAW-1:0]        reg_addr,
   input logic                  reg_wr,
   input logic [7:0]            reg_wdata,
   input logic                  fetch_valid,
   input logic [ADDR_W-1:0]     fetch_addr,
   input logic                  swi_req,
   input logic [NCH-1:0]        en_vec,
   input logic [NCH-1:0]        flag_vec,
   input logic [NCH*ADDR_W-1:0] tgt_flat
);
   logic [NCH-1:0] same;
   logic           csr_wr;

   always_comb begin
      for (int i = 0; i < NCH; i++) same[i] = (fetch_addr == tgt_flat[i*ADDR_W +: ADDR_W]);
   end
   assign csr_wr = reg_wr && (reg_addr == RAW'(CSR_ADDR));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         fetch_valid && en_vec[i] && same[i] |=> flag_vec[i]); // R4
      AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_vec[i]) |-> $past(fetch_valid && en_vec[i] && same[i])); // R5
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         flag_vec[i] && !(csr_wr && !reg_wdata[fmi_pkg::flag_pos(i)]) |=> flag_vec[i]); // R7
      AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_wr |=> $stable(tgt_flat[i*ADDR_W +: ADDR_W])); // R9
   end

   AST_REQ_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && |(en_vec & same & ~flag_vec) |=> swi_req); // R4
   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      swi_req |-> $past(fetch_valid && |(en_vec & same & ~flag_vec))); // R8
   AST_NO_FETCH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> !swi_req); // R3
endmodule

bind fetch_match_irq fmi_checker #(
   .ADDR_W(ADDR_W), .NCH(NCH), .RAW(RAW), .CSR_ADDR(CSR_ADDR)
) u_fmi_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .fetch_valid (fetch_valid),
   .fetch_addr  (fetch_addr),
   .swi_req     (swi_req),
   .en_vec      (en_vec),
   .flag_vec    (flag_vec),
   .tgt_flat    (tgt_flat)
);

// File: tb/tb_fetch_match_irq.sv
module tb_fetch_match_irq;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [15:0] CSR = 16'h1FF6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = 16'h0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h0;
   logic [7:0]  reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [23:0] fetch_addr = 24'h0;
   logic        swi_req;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fetch_match_irq dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .swi_req(swi_req)
   );

   // {enable byte, fetch address, expected request, expected csr}
   localparam logic [40:0] VEC [8] = '{
      {8'h05, 24'h123456, 1'b1, 8'h07},
      {8'h05, 24'hABCDEF, 1'b1, 8'h0D},
      {8'h04, 24'h123456, 1'b0, 8'h04},
      {8'h01, 24'hABCDEF, 1'b0, 8'h01},
      {8'h05, 24'h003456, 1'b0, 8'h05},
      {8'h05, 24'h123457, 1'b0, 8'h05},
      {8'h05, 24'hAB0DEF, 1'b0, 8'h05},
      {8'h00, 24'h123456, 1'b0, 8'h00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // one fetch cycle; on return the request cycle is current
   task automatic fetch(input logic [23:0] a, input logic v);
      @(negedge clk);
      fetch_addr = a; fetch_valid = v;
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic load_tgt(input int ch, input logic [23:0] t);
      for (int b = 0; b < 3; b++) wr(16'h1FF0 + 16'(ch*3 + b), t[b*8 +: 8]);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R2 reset state
      rd(CSR, d);            check("R2 reset csr", d, 8'h00);
      check("R2 reset req", swi_req, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 byte readback at each address
      load_tgt(0, 24'h123456);
      load_tgt(1, 24'hABCDEF);
      rd(16'h1FF0, d); check("R1 ch0 low", d, 8'h56);
      rd(16'h1FF1, d); check("R1 ch0 mid", d, 8'h34);
      rd(16'h1FF2, d); check("R1 ch0 high", d, 8'h12);
      rd(16'h1FF3, d); check("R1 ch1 low", d, 8'hEF);
      rd(16'h1FF4, d); check("R1 ch1 mid", d, 8'hCD);
      rd(16'h1FF5, d); check("R1 ch1 high", d, 8'hAB);

      // table walk: R4, R5, R10
      for (int k = 0; k < 8; k++) begin
         wr(CSR, VEC[k][40:33]);
         fetch(VEC[k][32:9], 1'b1);
         check($sformatf("R4/R5/R10 vec%0d req", k), swi_req, VEC[k][8]);
         rd(CSR, d);
         check($sformatf("R4/R5/R10 vec%0d csr", k), d, VEC[k][7:0]);
         @(negedge clk);
         check($sformatf("R4 vec%0d pulse end", k), swi_req, 1'b0);
      end

      // R3 no strobe, no compare
      wr(CSR, 8'h05);
      fetch(24'h123456, 1'b0);
      check("R3 req", swi_req, 1'b0);
      rd(CSR, d); check("R3 csr", d, 8'h05);

      // R7 writing 1 to flag bits does not set them
      wr(CSR, 8'h0F);
      rd(CSR, d); check("R7 write one", d, 8'h05);

      // R8 repeated match with flag set
      fetch(24'h123456, 1'b1);
      check("R8 first req", swi_req, 1'b1);
      fetch(24'h123456, 1'b1);
      check("R8 repeat req", swi_req, 1'b0);
      repeat (3) @(negedge clk);
      rd(CSR, d); check("R7 sticky", d, 8'h07);
      wr(CSR, 8'h07);
      rd(CSR, d); check("R7 keep on write 1", d, 8'h07);

      // R7 match and clear in the same cycle: flag stays
      @(negedge clk);
      reg_addr = CSR; reg_wdata = 8'h05; reg_wr = 1'b1;
      fetch_addr = 24'h123456; fetch_valid = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; fetch_valid = 1'b0;
      check("R8 no req on set flag", swi_req, 1'b0);
      rd(CSR, d); check("R7 set wins", d, 8'h07);
      wr(CSR, 8'h05);
      rd(CSR, d); check("R7 clear", d, 8'h05);

      // R6 both channels match together
      load_tgt(1, 24'h123456);
      fetch(24'h123456, 1'b1);
      check("R6 req", swi_req, 1'b1);
      rd(CSR, d); check("R6 csr", d, 8'h0F);
      @(negedge clk);
      check("R6 single pulse", swi_req, 1'b0);

      // R9 unmapped address
      wr(16'h1FF7, 8'hFF);
      wr(16'h1FEF, 8'h00);
      rd(16'h1FF7, d); check("R9 read zero", d, 8'h00);
      rd(CSR, d); check("R9 csr kept", d, 8'h0F);
      rd(16'h1FF0, d); check("R9 target kept", d, 8'h56);

      // R2 reset clears enables and flags
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(CSR, d); check("R2 after reset", d, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule